// File: doc/BRIEF.md
# SPI Status Flags and Request Steering

This block collects the conditions of a queued SPI controller with transmit and receive FIFOs. It turns them into status flags and request outputs. It watches the fill counts of both FIFOs and the controller's event pulses: end of frame, end of queue, a transfer started by an external master, and receive overflow. From these it keeps four sticky event flags and two level flags that follow the FIFO levels. A configuration register holds one enable bit per source. The two FIFO-level sources also each have a direction-select bit, which sends that source's request either to its own DMA request line or to the shared interrupt line.

Software reaches both registers through a simple one-bit-address register port. Address 0 is the status register, where writing 1 to an event flag bit clears that flag. Address 1 is the configuration register. The interrupt line and both DMA request lines are registered. Reset is synchronous and active high.

Top module: `spi_req_steer`

## Requirements
- R1: During and after a synchronous reset (`rst`=1), all event flags, enable bits and direction-select bits read as 0, and `irq`, `dma_tx` and `dma_rx` are low.
- R2: Status bit 4 reads 1 exactly when `tx_count` < TX_DEPTH, and status bit 5 reads 1 exactly when `rx_count` is non-zero. Writes to the status register leave both bits unchanged.
- R3: A one-cycle pulse sets an event flag on the next clock edge. `queue_end` sets status bit 0, `frame_done` sets bit 1 and `rx_ovf` sets bit 3.
- R4: When config bit 4 (transmit-fill enable) and config bit 5 (transmit DMA select) are both 1 and `tx_count` < TX_DEPTH, `dma_tx` is high one clock later. With bit 5 at 0, the same condition drives `irq` instead and `dma_tx` stays low.
- R5: When config bit 6 (receive-drain enable) and config bit 7 (receive DMA select) are both 1 and `rx_count` is non-zero, `dma_rx` is high one clock later. With bit 7 at 0, the same condition drives `irq` instead and `dma_rx` stays low.
- R6: A DMA request line falls on the first clock edge after its FIFO condition becomes false.
- R7: Status bit 2 (TX underflow) is set only when `is_slave`, `is_spi_cfg` and `ext_start` are all 1 and `tx_count` is 0 in the same cycle.
- R8: Writing 1 to status bits 3..0 clears those flags, and writing 0 leaves them unchanged. If a clear and a new event for the same flag land in the same cycle, the flag stays set.
- R9: `irq` is high one clock after any event flag whose enable is set is 1 (config bits 0..3 enable status bits 0..3), or after any interrupt-directed level source is active. `irq` stays low when no source is both enabled and active.
- R10: Reading address 1 returns the configuration register exactly as it was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_count | input | $clog2(TX_DEPTH+1) | Entries held in the transmit FIFO |
| rx_count | input | $clog2(RX_DEPTH+1) | Entries held in the receive FIFO |
| frame_done | input | 1 | Pulse at the end of each serial frame |
| queue_end | input | 1 | Pulse when the executing command ends the queue |
| is_slave | input | 1 | Controller is in slave mode |
| is_spi_cfg | input | 1 | Controller is in SPI configuration |
| ext_start | input | 1 | Strobe: an external master began a transfer |
| rx_ovf | input | 1 | Pulse on receive FIFO overflow |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status, 1 = configuration |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Combined interrupt request |
| dma_tx | output | 1 | Transmit-fill DMA request |
| dma_rx | output | 1 | Receive-drain DMA request |

## Verification
The hardest case to reach from the ports is a clear write and a new event hitting the same flag in the same cycle. The bench holds a write-1 to the transfer-complete bit on the same negative clock phase as a `frame_done` pulse, then reads the flag back. The underflow guard is also hard to reach, because it needs four inputs to agree at once. The bench drops one qualifier at a time (slave mode off, then a non-empty transmit FIFO) and confirms the flag stays clear each time.

// File: rtl/spi_req_pkg.sv
package spi_req_pkg;

    localparam int NEV = 4;
    localparam int EV_EOQ = 0;
    localparam int EV_TC  = 1;
    localparam int EV_UNF = 2;
    localparam int EV_OVF = 3;

    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_CFG    = 1'b1;

    typedef struct packed {
        logic drain_dma;
        logic drain_en;
        logic fill_dma;
        logic fill_en;
        logic ovf_en;
        logic unf_en;
        logic tc_en;
        logic eoq_en;
    } req_cfg_t;

    function automatic logic [NEV-1:0] ev_enables(req_cfg_t c);
        return {c.ovf_en, c.unf_en, c.tc_en, c.eoq_en};
    endfunction

endpackage

// File: rtl/spi_req_cfg.sv
module spi_req_cfg
    import spi_req_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output req_cfg_t   cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_en)
            cfg_q <= req_cfg_t'(wdata);
    end
endmodule

// File: rtl/spi_req_flags.sv
module spi_req_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_in,
    input  logic [N-1:0] clr_in,
    output logic [N-1:0] flags_q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags_q[i] <= 1'b0;
            else if (set_in[i])
                flags_q[i] <= 1'b1;      // new event beats a clear
            else if (clr_in[i])
                flags_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_req_route.sv
module spi_req_route
    import spi_req_pkg::*;
#(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4,
    localparam int TXCW = $clog2(TX_DEPTH + 1),
    localparam int RXCW = $clog2(RX_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TXCW-1:0] tx_count,
    input  logic [RXCW-1:0] rx_count,
    input  req_cfg_t        cfg,
    input  logic [NEV-1:0]  flags,
    output logic            fill_lvl,
    output logic            drain_lvl,
    output logic            irq,
    output logic            dma_tx,
    output logic            dma_rx
);
    logic fill_req, drain_req, irq_next;

    assign fill_lvl  = tx_count < TXCW'(TX_DEPTH);
    assign drain_lvl = rx_count != '0;
    assign fill_req  = fill_lvl  & cfg.fill_en;
    assign drain_req = drain_lvl & cfg.drain_en;

    always_comb begin
        irq_next = |(flags & ev_enables(cfg));
        irq_next = irq_next | (fill_req  & ~cfg.fill_dma);
        irq_next = irq_next | (drain_req & ~cfg.drain_dma);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq    <= 1'b0;
            dma_tx <= 1'b0;
            dma_rx <= 1'b0;
        end else begin
            irq    <= irq_next;
            dma_tx <= fill_req  & cfg.fill_dma;
            dma_rx <= drain_req & cfg.drain_dma;
        end
    end
endmodule

// File: rtl/spi_req_steer.sv
module spi_req_steer
    import spi_req_pkg::*;
#(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4,
    localparam int TXCW = $clog2(TX_DEPTH + 1),
    localparam int RXCW = $clog2(RX_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TXCW-1:0] tx_count,
    input  logic [RXCW-1:0] rx_count,
    input  logic            frame_done,
    input  logic            queue_end,
    input  logic            is_slave,
    input  logic            is_spi_cfg,
    input  logic            ext_start,
    input  logic            rx_ovf,
    input  logic            reg_wr,
    input  logic            reg_addr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    output logic            irq,
    output logic            dma_tx,
    output logic            dma_rx
);
    req_cfg_t       cfg_q;
    logic [NEV-1:0] ev_set, ev_clr, ev_q;
    logic           fill_lvl, drain_lvl, unf_hit;

    assign unf_hit = is_slave & is_spi_cfg & ext_start & (tx_count == '0);

    always_comb begin
        ev_set         = '0;
        ev_set[EV_EOQ] = queue_end;
        ev_set[EV_TC]  = frame_done;
        ev_set[EV_UNF] = unf_hit;
        ev_set[EV_OVF] = rx_ovf;
    end

    assign ev_clr = (reg_wr && reg_addr == ADDR_STATUS) ? reg_wdata[NEV-1:0] : '0;

    spi_req_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr && reg_addr == ADDR_CFG),
        .wdata (reg_wdata),
        .cfg_q (cfg_q)
    );

    spi_req_flags #(.N(NEV)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_in  (ev_set),
        .clr_in  (ev_clr),
        .flags_q (ev_q)
    );

    spi_req_route #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_route (
        .clk       (clk),
        .rst       (rst),
        .tx_count  (tx_count),
        .rx_count  (rx_count),
        .cfg       (cfg_q),
        .flags     (ev_q),
        .fill_lvl  (fill_lvl),
        .drain_lvl (drain_lvl),
        .irq       (irq),
        .dma_tx    (dma_tx),
        .dma_rx    (dma_rx)
    );

    always_comb begin
        if (reg_addr == ADDR_CFG)
            reg_rdata = cfg_q;
        else
            reg_rdata = {2'b00, drain_lvl, fill_lvl, ev_q};
    end
endmodule

// File: rtl/spi_req_steer_chk.sv
module spi_req_steer_chk #(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4,
    localparam int TXCW = $clog2(TX_DEPTH + 1),
    localparam int RXCW = $clog2(RX_DEPTH + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic [TXCW-1:0] tx_count,
    input logic [RXCW-1:0] rx_count,
    input logic            frame_done,
    input logic            is_slave,
    input logic            is_spi_cfg,
    input logic            ext_start,
    input logic            reg_wr,
    input logic            reg_addr,
    input logic [7:0]      reg_wdata,
    input logic [7:0]      cfg_bits,
    input logic [3:0]      flag_bits,
    input logic            irq,
    input logic            dma_tx,
    input logic            dma_rx
);
    a_r4_tx_dma_on: assert property (@(posedge clk) disable iff (rst)
        (tx_count < TXCW'(TX_DEPTH) && cfg_bits[4] && cfg_bits[5]) |=> dma_tx);

    a_r5_rx_dma_on: assert property (@(posedge clk) disable iff (rst)
        (rx_count != '0 && cfg_bits[6] && cfg_bits[7]) |=> dma_rx);

    a_r5_rx_dma_dir: assert property (@(posedge clk) disable iff (rst)
        !cfg_bits[7] |=> !dma_rx);

    a_r6_tx_dma_drop: assert property (@(posedge clk) disable iff (rst)
        !(tx_count < TXCW'(TX_DEPTH)) |=> !dma_tx);

    a_r3_tc_set: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> flag_bits[1]);

    a_r7_unf_guard: assert property (@(posedge clk) disable iff (rst)
        !(is_slave && is_spi_cfg && ext_start && tx_count == '0) |=> !$rose(flag_bits[2]));

    a_r8_tc_hold: assert property (@(posedge clk) disable iff (rst)
        (flag_bits[1] && !(reg_wr && reg_addr == 1'b0 && reg_wdata[1])) |=> flag_bits[1]);

    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        (cfg_bits == 8'h00) |=> !irq);
endmodule

bind spi_req_steer spi_req_steer_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_count   (tx_count),
    .rx_count   (rx_count),
    .frame_done (frame_done),
    .is_slave   (is_slave),
    .is_spi_cfg (is_spi_cfg),
    .ext_start  (ext_start),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .cfg_bits   (cfg_q),
    .flag_bits  (ev_q),
    .irq        (irq),
    .dma_tx     (dma_tx),
    .dma_rx     (dma_rx)
);

// File: tb/spi_req_steer_test.sv
`timescale 1ns/1ps
module spi_req_steer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] tx_count = '0;
    logic [2:0] rx_count = '0;
    logic       frame_done = 0, queue_end = 0, is_slave = 0, is_spi_cfg = 0;
    logic       ext_start = 0, rx_ovf = 0, reg_wr = 0, reg_addr = 0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, dma_tx, dma_rx;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spi_req_steer #(.TX_DEPTH(4), .RX_DEPTH(4)) uut (.*);

    // {cfg, tx_count, rx_count, irq, dma_tx, dma_rx}
    localparam logic [16:0] VEC [10] = '{
        {8'h00, 3'd0, 3'd0, 3'b000},
        {8'h30, 3'd1, 3'd0, 3'b010},
        {8'h10, 3'd1, 3'd0, 3'b100},
        {8'h10, 3'd4, 3'd0, 3'b000},
        {8'hC0, 3'd4, 3'd2, 3'b001},
        {8'h40, 3'd4, 3'd2, 3'b100},
        {8'h40, 3'd4, 3'd0, 3'b000},
        {8'hF0, 3'd3, 3'd4, 3'b011},
        {8'hB0, 3'd4, 3'd3, 3'b000},
        {8'h30, 3'd0, 3'd1, 3'b010}
    };

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic rd_reg(logic a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 outputs", {5'b0, irq, dma_tx, dma_rx}, 8'h00);
        @(negedge clk); rst = 0;
        @(negedge clk);
        rd_reg(1'b0, r); chk("R1 status", r, 8'h10);
        rd_reg(1'b1, r); chk("R1 config", r, 8'h00);

        // Table walk: R4 R5 R9
        for (int i = 0; i < 10; i++) begin
            tx_count = VEC[i][8:6];
            rx_count = VEC[i][5:3];
            wr_reg(1'b1, VEC[i][16:9]);
            @(negedge clk); @(negedge clk);
            chk($sformatf("R4/R5/R9 vec%0d", i), {5'b0, irq, dma_tx, dma_rx}, {5'b0, VEC[i][2:0]});
        end

        // R10 readback
        wr_reg(1'b1, 8'hA5);
        rd_reg(1'b1, r); chk("R10 readback", r, 8'hA5);
        wr_reg(1'b1, 8'h00);
        @(negedge clk);

        // R6: DMA drops one edge after condition goes false
        tx_count = 3'd2; rx_count = 3'd0;
        wr_reg(1'b1, 8'h30);
        @(negedge clk);
        chk("R6 dma_tx up", {7'b0, dma_tx}, 8'h01);
        tx_count = 3'd4;
        @(negedge clk);
        chk("R6 dma_tx down", {7'b0, dma_tx}, 8'h00);
        wr_reg(1'b1, 8'h00);

        // R2: level bits follow counts, ignore writes
        tx_count = 3'd4; rx_count = 3'd1;
        wr_reg(1'b0, 8'hF0);
        rd_reg(1'b0, r); chk("R2 levels", r, 8'h20);

        // R3: event pulses set flags
        @(negedge clk); frame_done = 1; queue_end = 1; rx_ovf = 1;
        @(negedge clk); frame_done = 0; queue_end = 0; rx_ovf = 0;
        rd_reg(1'b0, r); chk("R3 flags", r, 8'h2B);

        // R8: write 0 no effect, write 1 clears
        wr_reg(1'b0, 8'h00);
        rd_reg(1'b0, r); chk("R8 write0", r, 8'h2B);
        wr_reg(1'b0, 8'h09);
        rd_reg(1'b0, r); chk("R8 write1", r, 8'h22);

        // R8: set beats clear in the same cycle
        @(negedge clk);
        reg_wr = 1; reg_addr = 0; reg_wdata = 8'h02; frame_done = 1;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0; frame_done = 0;
        rd_reg(1'b0, r); chk("R8 set wins", r, 8'h22);

        // R9: enabled event flag drives irq one edge later
        wr_reg(1'b1, 8'h02);
        @(negedge clk);
        chk("R9 irq tc", {7'b0, irq}, 8'h01);
        wr_reg(1'b0, 8'h02);
        @(negedge clk);
        chk("R9 irq cleared", {7'b0, irq}, 8'h00);
        wr_reg(1'b1, 8'h00);

        // R7: underflow qualification
        tx_count = 3'd0; rx_count = 3'd0; is_slave = 1; is_spi_cfg = 1;
        @(negedge clk); ext_start = 1;
        @(negedge clk); ext_start = 0;
        rd_reg(1'b0, r); chk("R7 unf set", r & 8'h04, 8'h04);
        wr_reg(1'b0, 8'h04);
        is_slave = 0;
        @(negedge clk); ext_start = 1;
        @(negedge clk); ext_start = 0;
        rd_reg(1'b0, r); chk("R7 not slave", r & 8'h04, 8'h00);
        is_slave = 1; tx_count = 3'd2;
        @(negedge clk); ext_start = 1;
        @(negedge clk); ext_start = 0;
        rd_reg(1'b0, r); chk("R7 tx not empty", r & 8'h04, 8'h00);

        // R1: reset clears flags and config
        wr_reg(1'b1, 8'hFF);
        @(negedge clk); rx_ovf = 1;
        @(negedge clk); rx_ovf = 0; rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        rd_reg(1'b1, r); chk("R1 config after reset", r, 8'h00);
        rd_reg(1'b0, r); chk("R1 flags after reset", r & 8'h0F, 8'h00);
        chk("R1 outputs after reset", {5'b0, irq, dma_tx, dma_rx}, 8'h00);

        finish_run();
    end
endmodule